// File: doc/BRIEF.md
# Attribute Controller Host Register Interface

This block is the processor-facing register file of a display attribute controller. The host reaches it through a single write port. Successive writes on that port alternate between selecting a register and loading it. A separate read strobe returns the selected register. A one-bit phase register tracks whether the next write is a selection or a load. A read always resets that phase, so software can force a known state before it starts a sequence.

The selection write also carries a screen-enable bit. While the screen is enabled, the sixteen palette entries are protected against writes. The five control registers stay writable. These are mode control, border colour, plane enable, pixel panning and colour select. Every stored value is exported to the pixel path at all times.

The block also produces two one-cycle pulses. The first tells the pixel path to recompute all sixteen palette-to-DAC mappings. The second tells it to refresh its blink-versus-intensity setting.

Top module: `attr_regs`

## Requirements
- R1: A synchronous active-high reset clears every register, the screen-enable flag and both pulses, and leaves the port in the select phase.
- R2: In the select phase, a write stores bits 4:0 as the current register number and bit 5 as the screen-enable flag, then moves to the load phase. A write in the load phase goes to the selected register and returns to the select phase.
- R3: Register numbers 0x00 to 0x0F are palette entries. A load to one of them keeps the low 6 bits of the data, and those 6 bits appear on that entry's 6-bit slice of `palFlat` (entry n at bits 6n+5:6n).
- R4: While the screen-enable flag is 1, a load to a palette entry leaves the entry unchanged. The phase still returns to select.
- R5: Loads to the control registers are stored as follows. Number 0x10 is mode control (8 bits) and 0x11 is border colour (low 6 bits kept). Number 0x12 is plane enable (8 bits), 0x13 is pixel panning (low 4 bits kept) and 0x14 is colour select (8 bits).
- R6: `rdData` shows the selected register combinationally, with palette and border values zero-extended. A cycle with `rdEn` high returns the port to the select phase.
- R7: A load to a register number above 0x14 changes no register, and `rdData` reads zero while such a number is selected.
- R8: `remapPulse` is high for exactly the one cycle after a load that flips mode-control bit 7 or changes colour select to a different value. A load that changes neither leaves it low.
- R9: `blinkPulse` is high for exactly the one cycle after a load that flips mode-control bit 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Write strobe for the shared select/load port |
| wrData | input | 8 | Write data |
| rdEn | input | 1 | One-cycle read strobe; resets the phase |
| rdData | output | 8 | Value of the selected register |
| screenOn | output | 1 | Screen-enable flag from the last select write |
| palFlat | output | 96 | Sixteen 6-bit palette entries, entry 0 in the low bits |
| modeCtl | output | 8 | Mode control register |
| border | output | 6 | Border colour |
| planeEn | output | 8 | Plane enable |
| panning | output | 4 | Pixel panning |
| colorSel | output | 8 | Colour select |
| remapPulse | output | 1 | Palette mapping must be recomputed |
| blinkPulse | output | 1 | Blink/intensity setting changed |

## Verification
The bench checks that a read strobe in the middle of a sequence really drops the pending load. A design that ignored it would put the next select byte into the previously selected register. It checks that palette writes with the screen on are dropped, yet still consume their load slot. A design that froze the phase would shift every later access by one.

It checks that loads to unused numbers land nowhere and read back zero. A design that wrapped the number would corrupt a palette entry. It also checks that rewriting an unchanged value produces no remap or blink pulse, which catches a design that pulses on every write.

// File: rtl/attr_pkg.sv
package attr_pkg;
  localparam int DATA_W    = 8;
  localparam int IDX_W     = 5;
  localparam int NUM_PAL   = 16;
  localparam int PAL_IDX_W = $clog2(NUM_PAL);
  localparam int COLOR_W   = 6;
  localparam int PAN_W     = 4;

  localparam logic [IDX_W-1:0] IDX_MODE   = 5'h10;
  localparam logic [IDX_W-1:0] IDX_BORDER = 5'h11;
  localparam logic [IDX_W-1:0] IDX_PLANE  = 5'h12;
  localparam logic [IDX_W-1:0] IDX_PAN    = 5'h13;
  localparam logic [IDX_W-1:0] IDX_SEL    = 5'h14;

  typedef struct packed {
    logic                 palWe;
    logic [PAL_IDX_W-1:0] palIdx;
    logic                 modeWe;
    logic                 borderWe;
    logic                 planeWe;
    logic                 panWe;
    logic                 selWe;
    logic [DATA_W-1:0]    data;
  } attrStrobe_t;
endpackage

// File: rtl/attr_ctrl.sv
module attr_ctrl
  import attr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  output attrStrobe_t       stb,
  output logic [IDX_W-1:0]  curIdx,
  output logic              screenOn,
  output logic              dataPhase
);
  logic loadWr;
  logic isPal;

  always_ff @(posedge clk) begin
    if (rst) begin
      dataPhase <= 1'b0;
      curIdx    <= '0;
      screenOn  <= 1'b0;
    end else begin
      if (wrEn) begin
        if (!dataPhase) begin
          curIdx    <= wrData[IDX_W-1:0];
          screenOn  <= wrData[IDX_W];
          dataPhase <= 1'b1;
        end else begin
          dataPhase <= 1'b0;
        end
      end
      if (rdEn) dataPhase <= 1'b0;
    end
  end

  assign loadWr = wrEn && dataPhase;
  assign isPal  = (curIdx[IDX_W-1:PAL_IDX_W] == '0);

  always_comb begin
    stb          = '0;
    stb.palIdx   = curIdx[PAL_IDX_W-1:0];
    stb.data     = wrData;
    stb.palWe    = loadWr && isPal && !screenOn;
    stb.modeWe   = loadWr && (curIdx == IDX_MODE);
    stb.borderWe = loadWr && (curIdx == IDX_BORDER);
    stb.planeWe  = loadWr && (curIdx == IDX_PLANE);
    stb.panWe    = loadWr && (curIdx == IDX_PAN);
    stb.selWe    = loadWr && (curIdx == IDX_SEL);
  end

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && !rdEn) |=> (dataPhase != $past(dataPhase)));

  // R6
  read_clears_phase_chk: assert property (@(posedge clk) disable iff (rst)
    rdEn |=> !dataPhase);

  // R4
  pal_lock_chk: assert property (@(posedge clk) disable iff (rst)
    stb.palWe |-> !screenOn);
endmodule

// File: rtl/attr_datapath.sv
module attr_datapath
  import attr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  attrStrobe_t                stb,
  input  logic [IDX_W-1:0]           curIdx,
  output logic [DATA_W-1:0]          rdData,
  output logic [NUM_PAL*COLOR_W-1:0] palFlat,
  output logic [DATA_W-1:0]          modeCtl,
  output logic [COLOR_W-1:0]         border,
  output logic [DATA_W-1:0]          planeEn,
  output logic [PAN_W-1:0]           panning,
  output logic [DATA_W-1:0]          colorSel,
  output logic                       remapPulse,
  output logic                       blinkPulse
);
  localparam int COLOR_PAD = DATA_W - COLOR_W;
  localparam int PAN_PAD   = DATA_W - PAN_W;

  logic [COLOR_W-1:0] pal [NUM_PAL];
  logic remapNext, blinkNext;

  for (genvar g = 0; g < NUM_PAL; g++) begin : g_pal
    always_ff @(posedge clk) begin
      if (rst) pal[g] <= '0;
      else if (stb.palWe && stb.palIdx == PAL_IDX_W'(g)) pal[g] <= stb.data[COLOR_W-1:0];
    end
    assign palFlat[g*COLOR_W +: COLOR_W] = pal[g];
  end

  assign remapNext = (stb.modeWe && (stb.data[7] != modeCtl[7])) ||
                     (stb.selWe && (stb.data != colorSel));
  assign blinkNext = stb.modeWe && (stb.data[3] != modeCtl[3]);

  always_ff @(posedge clk) begin
    if (rst) begin
      modeCtl    <= '0;
      border     <= '0;
      planeEn    <= '0;
      panning    <= '0;
      colorSel   <= '0;
      remapPulse <= 1'b0;
      blinkPulse <= 1'b0;
    end else begin
      if (stb.modeWe)   modeCtl  <= stb.data;
      if (stb.borderWe) border   <= stb.data[COLOR_W-1:0];
      if (stb.planeWe)  planeEn  <= stb.data;
      if (stb.panWe)    panning  <= stb.data[PAN_W-1:0];
      if (stb.selWe)    colorSel <= stb.data;
      remapPulse <= remapNext;
      blinkPulse <= blinkNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (curIdx[IDX_W-1:PAL_IDX_W] == '0)
      rdData = {{COLOR_PAD{1'b0}}, pal[curIdx[PAL_IDX_W-1:0]]};
    else begin
      case (curIdx)
        IDX_MODE:   rdData = modeCtl;
        IDX_BORDER: rdData = {{COLOR_PAD{1'b0}}, border};
        IDX_PLANE:  rdData = planeEn;
        IDX_PAN:    rdData = {{PAN_PAD{1'b0}}, panning};
        IDX_SEL:    rdData = colorSel;
        default:    rdData = '0;
      endcase
    end
  end

  // R3
  pal_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !stb.palWe |=> $stable(palFlat));

  // R7
  unknown_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (curIdx > IDX_SEL) |-> (rdData == '0));

  // R8
  remap_cause_chk: assert property (@(posedge clk) disable iff (rst)
    remapPulse |-> (($past(modeCtl[7]) != modeCtl[7]) || ($past(colorSel) != colorSel)));

  // R9
  blink_cause_chk: assert property (@(posedge clk) disable iff (rst)
    blinkPulse |-> ($past(modeCtl[3]) != modeCtl[3]));
endmodule

// File: rtl/attr_regs.sv
module attr_regs
  import attr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wrEn,
  input  logic [DATA_W-1:0]          wrData,
  input  logic                       rdEn,
  output logic [DATA_W-1:0]          rdData,
  output logic                       screenOn,
  output logic [NUM_PAL*COLOR_W-1:0] palFlat,
  output logic [DATA_W-1:0]          modeCtl,
  output logic [COLOR_W-1:0]         border,
  output logic [DATA_W-1:0]          planeEn,
  output logic [PAN_W-1:0]           panning,
  output logic [DATA_W-1:0]          colorSel,
  output logic                       remapPulse,
  output logic                       blinkPulse
);
  attrStrobe_t      stb;
  logic [IDX_W-1:0] curIdx;
  logic             dataPhase;

  attr_ctrl u_ctrl (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .stb(stb), .curIdx(curIdx), .screenOn(screenOn), .dataPhase(dataPhase)
  );

  attr_datapath u_dp (
    .clk(clk), .rst(rst), .stb(stb), .curIdx(curIdx), .rdData(rdData),
    .palFlat(palFlat), .modeCtl(modeCtl), .border(border), .planeEn(planeEn),
    .panning(panning), .colorSel(colorSel), .remapPulse(remapPulse),
    .blinkPulse(blinkPulse)
  );

  // R1
  reset_phase_chk: assert property (@(posedge clk) rst |=> (!dataPhase && !remapPulse && !blinkPulse));
endmodule

// File: tb/attr_regs_bench.sv
module attr_regs_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        rdEn = 1'b0;
  logic [7:0]  rdData;
  logic        screenOn;
  logic [95:0] palFlat;
  logic [7:0]  modeCtl;
  logic [5:0]  border;
  logic [7:0]  planeEn;
  logic [3:0]  panning;
  logic [7:0]  colorSel;
  logic        remapPulse;
  logic        blinkPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_regs u_attr_regs (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rdData(rdData), .screenOn(screenOn), .palFlat(palFlat), .modeCtl(modeCtl),
    .border(border), .planeEn(planeEn), .panning(panning), .colorSel(colorSel),
    .remapPulse(remapPulse), .blinkPulse(blinkPulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rst = 1'b1; wrEn = 1'b0; rdEn = 1'b0;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] v);
    @(negedge clk); wrEn = 1'b1; wrData = v;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdPulse();
    @(negedge clk); rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [4:0] idx, input logic [7:0] v, input logic scr);
    wr({2'b00, scr, idx});
    wr(v);
  endtask

  task automatic readReg(input logic [4:0] idx, output logic [7:0] v);
    wr({3'b000, idx});
    v = rdData;
    rdPulse();
  endtask

  task automatic testReset();
    doReset();
    check("R1 modeCtl", modeCtl, 0);
    check("R1 palFlat", palFlat[31:0], 0);
    check("R1 screenOn", screenOn, 0);
    check("R1 remapPulse", remapPulse, 0);
    check("R1 blinkPulse", blinkPulse, 0);
    // R1: first write must be a select write
    writeReg(5'h12, 8'h5A, 1'b0);
    check("R1 R2 phase after reset", planeEn, 8'h5A);
  endtask

  task automatic testPalette();
    logic [7:0] v;
    doReset();
    for (int p = 0; p < 16; p++) writeReg(p[4:0], 8'hC0 | 8'(p * 3), 1'b0);
    for (int p = 0; p < 16; p++) begin
      readReg(p[4:0], v);
      check("R3 palette readback", v, (p * 3) & 8'h3F);
      check("R3 palFlat slice", palFlat[p*6 +: 6], (p * 3) & 6'h3F);
    end
  endtask

  task automatic testLock();
    logic [7:0] v;
    doReset();
    writeReg(5'h03, 8'h15, 1'b0);
    writeReg(5'h03, 8'h2A, 1'b1);
    check("R4 screenOn set", screenOn, 1);
    check("R4 locked entry", palFlat[23:18], 6'h15);
    writeReg(5'h11, 8'h07, 1'b1);
    check("R4 phase after locked write", border, 6'h07);
    readReg(5'h03, v);
    check("R4 locked readback", v, 8'h15);
    check("R2 screenOn cleared", screenOn, 0);
  endtask

  task automatic testCtrl();
    logic [7:0] v;
    doReset();
    writeReg(5'h10, 8'hA5, 1'b0);
    writeReg(5'h11, 8'hFF, 1'b0);
    writeReg(5'h12, 8'h0F, 1'b0);
    writeReg(5'h13, 8'h9B, 1'b0);
    writeReg(5'h14, 8'h0C, 1'b0);
    check("R5 modeCtl", modeCtl, 8'hA5);
    check("R5 border", border, 6'h3F);
    check("R5 planeEn", planeEn, 8'h0F);
    check("R5 panning", panning, 4'hB);
    check("R5 colorSel", colorSel, 8'h0C);
    readReg(5'h11, v); check("R6 border read", v, 8'h3F);
    readReg(5'h13, v); check("R6 panning read", v, 8'h0B);
    readReg(5'h10, v); check("R6 mode read", v, 8'hA5);
  endtask

  task automatic testReadClears();
    doReset();
    wr(8'h12);
    rdPulse();
    wr(8'h11);
    wr(8'h3F);
    check("R6 read resets phase border", border, 6'h3F);
    check("R6 read resets phase plane", planeEn, 8'h00);
  endtask

  task automatic testUnknown();
    logic [7:0] v;
    doReset();
    writeReg(5'h15, 8'hFF, 1'b0);
    writeReg(5'h1F, 8'hFF, 1'b0);
    check("R7 palette untouched", palFlat[31:0], 0);
    check("R7 palette untouched hi", palFlat[95:64], 0);
    check("R7 mode untouched", modeCtl, 0);
    check("R7 sel untouched", colorSel, 0);
    readReg(5'h15, v); check("R7 read zero 0x15", v, 0);
    readReg(5'h1F, v); check("R7 read zero 0x1F", v, 0);
    writeReg(5'h11, 8'h2A, 1'b0);
    check("R7 phase back to select", border, 6'h2A);
  endtask

  task automatic testRemap();
    doReset();
    writeReg(5'h10, 8'h80, 1'b0);
    check("R8 pulse on bit7 flip", remapPulse, 1);
    @(negedge clk);
    check("R8 pulse one cycle", remapPulse, 0);
    writeReg(5'h10, 8'h81, 1'b0);
    check("R8 no pulse bit7 same", remapPulse, 0);
    writeReg(5'h14, 8'h05, 1'b0);
    check("R8 pulse on colorSel change", remapPulse, 1);
    writeReg(5'h14, 8'h05, 1'b0);
    check("R8 no pulse colorSel same", remapPulse, 0);
    writeReg(5'h11, 8'h01, 1'b0);
    check("R8 no pulse other reg", remapPulse, 0);
  endtask

  task automatic testBlink();
    doReset();
    writeReg(5'h10, 8'h08, 1'b0);
    check("R9 pulse on bit3 flip", blinkPulse, 1);
    check("R8 no remap on bit3 flip", remapPulse, 0);
    @(negedge clk);
    check("R9 pulse one cycle", blinkPulse, 0);
    writeReg(5'h10, 8'h0C, 1'b0);
    check("R9 no pulse bit3 same", blinkPulse, 0);
    writeReg(5'h10, 8'h04, 1'b0);
    check("R9 pulse on bit3 clear", blinkPulse, 1);
  endtask

  initial begin
    testReset();
    testPalette();
    testLock();
    testCtrl();
    testReadClears();
    testUnknown();
    testRemap();
    testBlink();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule